// File: doc/BRIEF.md
# Multiplexed-bus DMA cycle sequencer

This block is the bus-master engine of a general-purpose DMA port. A user device asks for each word with a rising edge on a cycle-request line. The block then latches the device's control lines and write data and lowers a BUSY line. It wins ownership of a shared multiplexed address/data bus through a request/grant/acknowledge exchange and runs one bus cycle. When the cycle is over it raises BUSY again. The device's two-bit cycle code picks the cycle: a word read, a read that pauses for a write to the same location, a word write, or a byte write.

Software arms a transfer with a start pulse, a two's-complement word count and a starting word address. These values come in as plain inputs. The engine counts words and addresses, and either increment can be held off per word by the device. In burst mode one request moves the whole block without giving up the bus. If a slave does not answer, or if the write half of a read-pause cycle comes too late, a nonexistent-memory flag is set and the engine stops. An attention input from the device also ends the transfer and sets its own error flag.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset `dma_ready` and `busy_n` are 1, and `err_nex`, `err_attn`, `bus_dmr`, `bus_sack`, `bus_sync`, `bus_din` and `bus_dout` are 0.
- R2: A `prog_go` pulse while `dma_ready` is 1 loads the count and address, clears both error flags and drops `dma_ready`. A rising edge on `usr_req` while `dma_ready` is 1 is ignored: no bus request is made and `busy_n` stays 1.
- R3: Bus ownership follows a fixed order: `bus_dmr` is raised, `bus_sack` rises only after grant-in is seen and at that point `bus_dmr` is already low, and `bus_sync` does not rise until grant-in has gone low again.
- R4: The cycle code on `usr_ctl` is 00 read, 01 read-pause, 10 word write, 11 byte write. For a write, the address phase drives the address with `bus_wtbt` high before `bus_sync` rises. The data phase drives the latched write data with `bus_dout`. `bus_wtbt` stays high in the data phase only for a byte write. A byte write puts `usr_a0` on address bit 0, and word cycles drive bit 0 as 0.
- R5: A read drives the address with `bus_wtbt` low, then raises `bus_din` with the address bus released. The word on `bus_ad_in` when the reply arrives appears on `usr_rdata`.
- R6: A read-pause cycle keeps `bus_sync` high after its read. It raises `busy_n` with the read word on `usr_rdata`. The next `usr_req` rising edge latches new write data, which is written to the same address with no new address phase.
- R7: Outside burst mode `busy_n` returns to 1 after each word. The word address advances by one per word only when `usr_ba_en` was 1 at the request, and the count advances only when `usr_wc_en` was 1.
- R8: When the count advances to zero the transfer ends and `dma_ready` returns to 1.
- R9: If no reply comes within 15 µs of a data strobe, `err_nex` and `dma_ready` are set and all strobes, `bus_sync` and `bus_sack` are released.
- R10: If the second request of a read-pause cycle does not come within 30 µs, `err_nex` and `dma_ready` are set and `bus_sync` is released.
- R11: With `usr_single` low at the request, the whole remaining block is transferred back to back under a single `bus_sack` assertion, and `busy_n` stays 0 until the end.
- R12: `usr_attn` high while a transfer is armed and idle, or at the end of a word, ends the transfer and sets `dma_ready` and `err_attn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_go | input | 1 | Start pulse that arms a transfer |
| prog_count | input | WCW (16) | Two's complement of the word count |
| prog_waddr | input | AW-1 (17) | Starting word address |
| dma_ready | output | 1 | High when no transfer is armed |
| err_nex | output | 1 | Nonexistent-memory error |
| err_attn | output | 1 | Transfer ended by attention |
| usr_req | input | 1 | Cycle request, acts on its rising edge |
| usr_ctl | input | 2 | Cycle code |
| usr_single | input | 1 | 1 single word per request, 0 burst |
| usr_a0 | input | 1 | Address bit 0 for byte writes |
| usr_wc_en | input | 1 | Enable count advance for this word |
| usr_ba_en | input | 1 | Enable address advance for this word |
| usr_attn | input | 1 | Attention, ends the transfer |
| usr_wdata | input | DW (16) | Write data from the device |
| usr_rdata | output | DW (16) | Last word read from the bus |
| busy_n | output | 1 | Low while a word is in progress |
| bus_dmr | output | 1 | Bus request |
| bus_dmgi | input | 1 | Bus grant in |
| bus_sack | output | 1 | Select acknowledge, bus owned |
| bus_sync | output | 1 | Address valid / cycle in progress |
| bus_din | output | 1 | Input data strobe |
| bus_dout | output | 1 | Output data strobe |
| bus_wtbt | output | 1 | Write / byte strobe |
| bus_rply | input | 1 | Slave reply |
| bus_ad_out | output | DW (16) | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_out` |
| bus_ext_out | output | AW-DW (2) | Upper address bits |
| bus_ad_in | input | DW (16) | Multiplexed data in |

## Verification
The hardest case to reach from the ports is the read-pause cycle. The bus stays owned with `bus_sync` high while the device looks at the read word and makes a second request. Its 30 µs expiry is just as hard. The bench drives the first request, waits for `busy_n` to rise in the middle of the cycle and checks the still-held `bus_sync` and the read word. It then either makes the second request or stays silent for more than 1500 clocks to reach the timeout. A muted slave model reaches the reply timeout, and a single burst request is checked to raise `bus_sack` exactly once.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      CYC_READ       = 2'b00,
      CYC_READ_PAUSE = 2'b01,
      CYC_WRITE      = 2'b10,
      CYC_WRITE_BYTE = 2'b11
   } cyc_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BREQ,
      ST_BACK,
      ST_ADDR,
      ST_ASYNC,
      ST_XFER,
      ST_DROP,
      ST_PAUSE,
      ST_DONE
   } seq_state_e;

   function automatic logic cyc_is_write(cyc_e c);
      return c[1];
   endfunction

   function automatic int us_to_cycles(longint clk_hz, int us);
      return int'((clk_hz / 64'd1_000_000) * us);
   endfunction

endpackage

// File: rtl/dma_in_sync.sv
module dma_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   logic prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= q;
   end

   assign rise = q & ~prev;
endmodule

// File: rtl/dma_watch.sv
module dma_watch #(
   parameter int LIMIT = 750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
   parameter int AW  = 18,
   parameter int WCW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [WCW-1:0] count_init,
   input  logic [AW-2:0] waddr_init,
   input  logic          step,
   input  logic          wc_en,
   input  logic          ba_en,
   output logic [AW-2:0] waddr,
   output logic          wc_last
);
   logic [WCW-1:0] wc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wc    <= '0;
         waddr <= '0;
      end else if (load) begin
         wc    <= count_init;
         waddr <= waddr_init;
      end else if (step) begin
         if (wc_en) wc    <= wc + 1'b1;
         if (ba_en) waddr <= waddr + 1'b1;
      end
   end

   assign wc_last = &wc;
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
   import dma_seq_pkg::*;
#(
   parameter int     DW          = 16,
   parameter int     AW          = 18,
   parameter int     WCW         = 16,
   parameter longint CLK_HZ      = 50_000_000,
   parameter int     REPLY_US    = 15,
   parameter int     PAUSE_US    = 30,
   parameter int     SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prog_go,
   input  logic [WCW-1:0] prog_count,
   input  logic [AW-2:0]  prog_waddr,
   output logic           dma_ready,
   output logic           err_nex,
   output logic           err_attn,
   input  logic           usr_req,
   input  logic [1:0]     usr_ctl,
   input  logic           usr_single,
   input  logic           usr_a0,
   input  logic           usr_wc_en,
   input  logic           usr_ba_en,
   input  logic           usr_attn,
   input  logic [DW-1:0]  usr_wdata,
   output logic [DW-1:0]  usr_rdata,
   output logic           busy_n,
   output logic           bus_dmr,
   input  logic           bus_dmgi,
   output logic           bus_sack,
   output logic           bus_sync,
   output logic           bus_din,
   output logic           bus_dout,
   output logic           bus_wtbt,
   input  logic           bus_rply,
   output logic [DW-1:0]  bus_ad_out,
   output logic           bus_ad_oe,
   output logic [AW-DW-1:0] bus_ext_out,
   input  logic [DW-1:0]  bus_ad_in
);
   localparam int REPLY_CYC = us_to_cycles(CLK_HZ, REPLY_US);
   localparam int PAUSE_CYC = us_to_cycles(CLK_HZ, PAUSE_US);

   generate
      if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
         $error("DW must be a whole number of bytes");
      end
      if (AW <= DW) begin : g_bad_aw
         $error("AW must exceed DW");
      end
      if (REPLY_CYC < 4 || PAUSE_CYC < 4) begin : g_bad_clk
         $error("CLK_HZ too low for the timeouts");
      end
   endgenerate

   seq_state_e st;
   cyc_e       cyc_q;
   logic       burst_q, a0_q, wcen_q, baen_q, rmw_wr_q;
   logic [DW-1:0] wdata_q, rdata_q;
   logic       ready_q, nex_q, attn_err_q;

   logic req_s, req_rise, dmgi_s, rply_s, attn_s;
   logic unused_rise_a, unused_rise_b, unused_rise_c;

   dma_in_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(usr_req), .q(req_s), .rise(req_rise));
   dma_in_sync #(.STAGES(SYNC_STAGES)) u_gnt_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_dmgi), .q(dmgi_s), .rise(unused_rise_a));
   dma_in_sync #(.STAGES(SYNC_STAGES)) u_rply_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_rply), .q(rply_s), .rise(unused_rise_b));
   dma_in_sync #(.STAGES(SYNC_STAGES)) u_attn_sync (
      .clk(clk), .rst_n(rst_n), .d(usr_attn), .q(attn_s), .rise(unused_rise_c));

   logic          cnt_load, cnt_step, wc_last, wc_hit;
   logic [AW-2:0] waddr;

   assign cnt_load = (st == ST_IDLE) && ready_q && prog_go;
   assign cnt_step = (st == ST_DONE);
   assign wc_hit   = wcen_q && wc_last;

   dma_xfer_count #(.AW(AW), .WCW(WCW)) u_count (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .count_init(prog_count),
      .waddr_init(prog_waddr), .step(cnt_step), .wc_en(wcen_q), .ba_en(baen_q),
      .waddr(waddr), .wc_last(wc_last));

   logic rply_tmo, pause_tmo;

   dma_watch #(.LIMIT(REPLY_CYC)) u_rply_watch (
      .clk(clk), .rst_n(rst_n), .run(st == ST_XFER), .expired(rply_tmo));
   dma_watch #(.LIMIT(PAUSE_CYC)) u_pause_watch (
      .clk(clk), .rst_n(rst_n), .run(st == ST_PAUSE), .expired(pause_tmo));

   logic wr_phase, addr_phase;
   logic [AW-1:0] full_addr;

   assign wr_phase   = cyc_is_write(cyc_q) || rmw_wr_q;
   assign addr_phase = (st == ST_ADDR) || (st == ST_ASYNC);
   assign full_addr  = {waddr, (cyc_q == CYC_WRITE_BYTE) ? a0_q : 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cyc_q      <= CYC_READ;
         burst_q    <= 1'b0;
         a0_q       <= 1'b0;
         wcen_q     <= 1'b0;
         baen_q     <= 1'b0;
         rmw_wr_q   <= 1'b0;
         wdata_q    <= '0;
         rdata_q    <= '0;
         ready_q    <= 1'b1;
         nex_q      <= 1'b0;
         attn_err_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (ready_q) begin
                  if (prog_go) begin
                     ready_q    <= 1'b0;
                     nex_q      <= 1'b0;
                     attn_err_q <= 1'b0;
                  end
               end else if (attn_s) begin
                  ready_q    <= 1'b1;
                  attn_err_q <= 1'b1;
               end else if (req_rise) begin
                  cyc_q    <= cyc_e'(usr_ctl);
                  burst_q  <= !usr_single;
                  a0_q     <= usr_a0;
                  wcen_q   <= usr_wc_en;
                  baen_q   <= usr_ba_en;
                  wdata_q  <= usr_wdata;
                  rmw_wr_q <= 1'b0;
                  st       <= ST_BREQ;
               end
            end
            ST_BREQ:  if (dmgi_s)  st <= ST_BACK;
            ST_BACK:  if (!dmgi_s) st <= ST_ADDR;
            ST_ADDR:  st <= ST_ASYNC;
            ST_ASYNC: st <= ST_XFER;
            ST_XFER: begin
               if (rply_s) begin
                  if (!wr_phase) rdata_q <= bus_ad_in;
                  st <= ST_DROP;
               end else if (rply_tmo) begin
                  nex_q   <= 1'b1;
                  ready_q <= 1'b1;
                  st      <= ST_IDLE;
               end
            end
            ST_DROP: begin
               if (!rply_s) begin
                  if (cyc_q == CYC_READ_PAUSE && !rmw_wr_q) st <= ST_PAUSE;
                  else                                      st <= ST_DONE;
               end
            end
            ST_PAUSE: begin
               if (req_rise) begin
                  wdata_q  <= usr_wdata;
                  rmw_wr_q <= 1'b1;
                  st       <= ST_XFER;
               end else if (pause_tmo) begin
                  nex_q   <= 1'b1;
                  ready_q <= 1'b1;
                  st      <= ST_IDLE;
               end
            end
            ST_DONE: begin
               rmw_wr_q <= 1'b0;
               if (wc_hit || attn_s) begin
                  ready_q    <= 1'b1;
                  attn_err_q <= attn_s;
                  st         <= ST_IDLE;
               end else if (burst_q) begin
                  wdata_q <= usr_wdata;
                  st      <= ST_ADDR;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_dmr     = (st == ST_BREQ);
      bus_sack    = (st != ST_IDLE) && (st != ST_BREQ);
      bus_sync    = (st == ST_ASYNC) || (st == ST_XFER) ||
                    (st == ST_DROP)  || (st == ST_PAUSE);
      bus_din     = (st == ST_XFER) && !wr_phase;
      bus_dout    = (st == ST_XFER) && wr_phase;
      bus_wtbt    = (addr_phase && cyc_is_write(cyc_q)) ||
                    (bus_dout && (cyc_q == CYC_WRITE_BYTE));
      bus_ad_oe   = addr_phase || bus_dout;
      bus_ad_out  = addr_phase ? full_addr[DW-1:0] : (bus_dout ? wdata_q : '0);
      bus_ext_out = addr_phase ? full_addr[AW-1:DW] : '0;
      busy_n      = (st == ST_IDLE) || (st == ST_PAUSE);
   end

   assign dma_ready = ready_q;
   assign err_nex   = nex_q;
   assign err_attn  = attn_err_q;
   assign usr_rdata = rdata_q;

   logic unused_ok;
   assign unused_ok = &{1'b0, req_s, unused_rise_a, unused_rise_b, unused_rise_c};
endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic dma_ready,
   input logic err_nex,
   input logic busy_n,
   input logic bus_dmr,
   input logic bus_sack,
   input logic bus_sync,
   input logic bus_din,
   input logic bus_dout,
   input logic bus_ad_oe
);
   AST_DIN_DOUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_din && bus_dout));                                          // R5
   AST_SYNC_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sync |-> (bus_sack && !bus_dmr));                             // R3
   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_sack) |-> $past(bus_dmr));                              // R3
   AST_DIN_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_din |-> !bus_ad_oe);                                          // R5
   AST_STROBE_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_din || bus_dout) |-> bus_sync);                              // R4
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ready |-> (busy_n && !bus_sack));                             // R8
   AST_NEX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_nex) |-> (!bus_sync && !bus_din && !bus_dout && !bus_sack)); // R9
   AST_BUSY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_din || bus_dout) |-> !busy_n);                               // R7
endmodule

bind dma_cycle_seq dma_cycle_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .dma_ready(dma_ready), .err_nex(err_nex),
   .busy_n(busy_n), .bus_dmr(bus_dmr), .bus_sack(bus_sack), .bus_sync(bus_sync),
   .bus_din(bus_din), .bus_dout(bus_dout), .bus_ad_oe(bus_ad_oe));

// File: tb/sim_dma_cycle_seq.sv
`timescale 1ns/1ps
module sim_dma_cycle_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        prog_go = 0;
   logic [15:0] prog_count = 0;
   logic [16:0] prog_waddr = 0;
   logic        dma_ready, err_nex, err_attn;
   logic        usr_req = 0, usr_single = 1, usr_a0 = 0, usr_wc_en = 1, usr_ba_en = 1, usr_attn = 0;
   logic [1:0]  usr_ctl = 0;
   logic [15:0] usr_wdata = 0, usr_rdata;
   logic        busy_n;
   logic        bus_dmr, bus_dmgi = 0, bus_sack, bus_sync, bus_din, bus_dout, bus_wtbt, bus_rply = 0;
   logic [15:0] bus_ad_out, bus_ad_in = 0;
   logic        bus_ad_oe;
   logic [1:0]  bus_ext_out;

   dma_cycle_seq u0 (.*);

   int n_chk = 0, n_err = 0;
   logic [15:0] mem [0:255];
   bit mute = 0;
   bit saw_dmr = 0;
   int n_sack_rise = 0;
   logic [17:0] la_addr[$];
   bit          la_wtbt[$];
   logic [15:0] ld_data[$];
   bit          ld_wtbt[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // grant model and per-clock reference of the bus rules
   initial begin
      logic p_sack = 0, p_sync = 0;
      int gdly = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (bus_dmr) saw_dmr = 1;
            if (bus_dmr && !bus_sack) begin
               gdly++;
               if (gdly >= 2) bus_dmgi = 1;
            end else gdly = 0;
            if (bus_sack && !p_sack) begin
               n_sack_rise++;
               chk("R3 grant seen before ack", {31'd0, bus_dmgi}, 1);
               chk("R3 request low at ack", {31'd0, bus_dmr}, 0);
               bus_dmgi = 0;
            end
            if (bus_sync && !p_sync) begin
               chk("R3 grant gone before sync", {31'd0, bus_dmgi}, 0);
               la_addr.push_back({bus_ext_out, bus_ad_out});
               la_wtbt.push_back(bus_wtbt);
            end
            chk("R5 no dual strobe", {31'd0, bus_din & bus_dout}, 0);
            p_sack = bus_sack;
            p_sync = bus_sync;
         end
      end
   end

   // slave memory model
   initial begin
      int dly = 0;
      logic [7:0] w;
      forever begin
         @(negedge clk);
         if ((bus_din || bus_dout) && !mute) begin
            dly++;
            if (dly == 2) begin
               w = la_addr[$][8:1];
               if (bus_din) bus_ad_in = mem[w];
               else begin
                  ld_data.push_back(bus_ad_out);
                  ld_wtbt.push_back(bus_wtbt);
                  if (!bus_wtbt) mem[w] = bus_ad_out;
                  else if (la_addr[$][0]) mem[w][15:8] = bus_ad_out[15:8];
                  else mem[w][7:0] = bus_ad_out[7:0];
               end
               bus_rply = 1;
            end
         end else begin
            dly = 0;
            bus_rply = 0;
         end
      end
   end

   task automatic clear_logs();
      la_addr.delete(); la_wtbt.delete(); ld_data.delete(); ld_wtbt.delete();
   endtask

   task automatic wait_busy(input logic v, input string tag);
      int k = 0;
      while (busy_n !== v && k < 4000) begin @(negedge clk); k++; end
      if (busy_n !== v) chk({tag, " handshake"}, {31'd0, busy_n}, {31'd0, v});
   endtask

   task automatic go(input logic [15:0] cnt, input logic [17:0] baddr);
      @(negedge clk);
      prog_go = 1; prog_count = cnt; prog_waddr = baddr[17:1];
      @(negedge clk);
      prog_go = 0;
      @(negedge clk);
   endtask

   task automatic xfer(input logic [1:0] c, input logic [15:0] d, input logic a0,
                       input logic wce, input logic bae, input string tag);
      usr_ctl = c; usr_wdata = d; usr_a0 = a0; usr_wc_en = wce; usr_ba_en = bae;
      @(negedge clk);
      usr_req = 1;
      wait_busy(0, tag);
      wait_busy(1, tag);
      usr_req = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_ready(input string tag);
      int k = 0;
      while (dma_ready !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
      chk({tag, " ready"}, {31'd0, dma_ready}, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready", {31'd0, dma_ready}, 1);
      chk("R1 busy_n", {31'd0, busy_n}, 1);
      chk("R1 errors", {30'd0, err_nex, err_attn}, 0);
      chk("R1 strobes", {27'd0, bus_dmr, bus_sack, bus_sync, bus_din, bus_dout}, 0);

      // R2 request ignored while ready
      saw_dmr = 0;
      usr_req = 1; repeat (12) @(negedge clk);
      chk("R2 no request while ready", {31'd0, saw_dmr}, 0);
      chk("R2 busy stays high", {31'd0, busy_n}, 1);
      usr_req = 0; repeat (4) @(negedge clk);

      // R2/R4/R5/R7/R8 word write, read, byte write
      mem[8'h21] = 16'h1234; mem[8'h22] = 16'h1111;
      go(16'hFFFD, 18'h040);
      chk("R2 go drops ready", {31'd0, dma_ready}, 0);
      clear_logs();
      xfer(2'b10, 16'hA5A5, 0, 1, 1, "R4");
      chk("R4 write address", la_addr[0], 18'h040);
      chk("R4 wtbt in address phase", {31'd0, la_wtbt[0]}, 1);
      chk("R4 write data", ld_data[0], 16'hA5A5);
      chk("R4 wtbt low in word data phase", {31'd0, ld_wtbt[0]}, 0);
      chk("R7 busy back high", {31'd0, busy_n}, 1);
      chk("R7 still armed", {31'd0, dma_ready}, 0);
      xfer(2'b00, 16'h0, 0, 1, 1, "R5");
      chk("R5 read address advanced", la_addr[1], 18'h042);
      chk("R5 wtbt low for read", {31'd0, la_wtbt[1]}, 0);
      chk("R5 read word", usr_rdata, 16'h1234);
      xfer(2'b11, 16'hBEEF, 1, 1, 1, "R4b");
      chk("R4 byte address bit0", la_addr[2], 18'h045);
      chk("R4 wtbt held for byte", {31'd0, ld_wtbt[1]}, 1);
      chk("R4 byte lane", mem[8'h22], 16'hBE11);
      chk("R8 count end ready", {31'd0, dma_ready}, 1);
      chk("R8 no error", {30'd0, err_nex, err_attn}, 0);

      // R7 increment inhibits
      go(16'hFFFE, 18'h080);
      clear_logs();
      xfer(2'b10, 16'h0001, 0, 1, 0, "R7a");
      xfer(2'b10, 16'h0002, 0, 1, 1, "R7b");
      chk("R7 address held", la_addr[1], 18'h080);
      chk("R7 held address data", mem[8'h40], 16'h0002);
      chk("R7 ready after two", {31'd0, dma_ready}, 1);
      go(16'hFFFF, 18'h0A0);
      clear_logs();
      xfer(2'b10, 16'h0003, 0, 0, 1, "R7c");
      chk("R7 count held", {31'd0, dma_ready}, 0);
      xfer(2'b10, 16'h0004, 0, 1, 1, "R7d");
      chk("R7 address advanced", la_addr[1], 18'h0A2);
      chk("R8 ready", {31'd0, dma_ready}, 1);

      // R6 read-pause
      mem[8'h60] = 16'h0F0F;
      go(16'hFFFF, 18'h0C0);
      clear_logs();
      xfer(2'b01, 16'h0, 0, 1, 1, "R6a");
      chk("R6 read word in pause", usr_rdata, 16'h0F0F);
      chk("R6 sync held in pause", {31'd0, bus_sync}, 1);
      chk("R6 armed in pause", {31'd0, dma_ready}, 0);
      xfer(2'b01, 16'h7777, 0, 1, 1, "R6b");
      chk("R6 written back", mem[8'h60], 16'h7777);
      chk("R6 single address phase", la_addr.size(), 1);
      chk("R6 ready", {31'd0, dma_ready}, 1);

      // R11 burst
      go(16'hFFFC, 18'h100);
      n_sack_rise = 0;
      usr_single = 0;
      xfer(2'b10, 16'h5A5A, 0, 1, 1, "R11");
      usr_single = 1;
      chk("R11 one bus ownership", n_sack_rise, 1);
      chk("R11 first word", mem[8'h80], 16'h5A5A);
      chk("R11 last word", mem[8'h83], 16'h5A5A);
      chk("R11 ready", {31'd0, dma_ready}, 1);

      // R9 reply timeout
      go(16'hFFFE, 18'h140);
      mute = 1;
      xfer(2'b10, 16'h9999, 0, 1, 1, "R9");
      chk("R9 nex set", {31'd0, err_nex}, 1);
      chk("R9 ready set", {31'd0, dma_ready}, 1);
      chk("R9 bus released", {29'd0, bus_sack, bus_sync, bus_dout}, 0);
      mute = 0;
      go(16'hFFFF, 18'h180);
      chk("R2 go clears nex", {31'd0, err_nex}, 0);

      // R10 pause timeout
      xfer(2'b01, 16'h0, 0, 1, 1, "R10");
      chk("R10 armed during pause", {31'd0, dma_ready}, 0);
      wait_ready("R10");
      chk("R10 nex set", {31'd0, err_nex}, 1);
      chk("R10 sync released", {31'd0, bus_sync}, 0);

      // R12 attention
      go(16'hFFFB, 18'h1C0);
      usr_attn = 1; repeat (6) @(negedge clk);
      chk("R12 idle attn ready", {31'd0, dma_ready}, 1);
      chk("R12 idle attn flag", {31'd0, err_attn}, 1);
      usr_attn = 0;
      go(16'hFFFB, 18'h1C0);
      chk("R12 go clears attn", {31'd0, err_attn}, 0);
      usr_ctl = 2'b10; usr_wdata = 16'h4444;
      @(negedge clk); usr_req = 1;
      wait_busy(0, "R12");
      usr_attn = 1;
      wait_busy(1, "R12");
      usr_req = 0; repeat (4) @(negedge clk);
      chk("R12 end attn ready", {31'd0, dma_ready}, 1);
      chk("R12 end attn flag", {31'd0, err_attn}, 1);
      chk("R12 word written", mem[8'hE0], 16'h4444);
      usr_attn = 0;
      repeat (5) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule